// File: doc/BRIEF.md
# Low-Power Clock Enable Controller

This block decides which system clocks run from four mode bits held in a CPU status word. It also decides when each of the two clock sources may be powered down: the internal digitally controlled oscillator (DCO) and the low-frequency crystal oscillator. The block receives each source clock as a phase level sampled in its own clock domain. It then produces enable strobes for three clocks:
- the auxiliary clock;
- the main clock, which feeds the CPU;
- the subsystem clock, which feeds the peripherals.

A status-word write loads the mode bits. When an interrupt is accepted, the block saves the mode bits and clears them, so the main clock and its source run while the handler executes. On return, a restore input reloads the mode bits in a single cycle. The handler may have modified that value, so the mode that resumes can differ from the one that was interrupted.

Each gated clock has its own gate register. A gate register changes only on a cycle in which its selected source phase is low, so an enable strobe can never be cut short or started in the middle of a high phase.

Top module: `lp_clock_gate`

## Requirements
- R1: On `sr_we`, the block loads four mode bits from `sr_wdata`:
  - bit 7 is subsystem-off;
  - bit 6 is DCO-off;
  - bit 5 is crystal-off;
  - bit 4 is main-off.

  All other bits of the word are ignored. After reset all four mode bits are 0. `mode_o` presents them in the order {bit7, bit6, bit5, bit4}.
- R2: `mclk_en` equals the main gate ANDed with the selected source phase. `selm[1]`=0 selects `dco_ph` and `selm[1]`=1 selects `xt_ph`; `selm[0]` has no effect. Once settled, the main gate equals NOT main-off.
- R3: `smclk_en` equals the subsystem gate ANDed with the selected source phase. `sels`=0 selects `dco_ph` and `sels`=1 selects `xt_ph`. Once settled, the subsystem gate equals NOT subsystem-off.
- R4: `aclk_en` always follows `xt_ph`, whatever the mode bits are.
- R5: A gate register takes its new value only on a clock edge at which its selected source phase is low. While that phase stays high, the gate holds its old value even if the mode bits have changed.
- R6: `dco_pd` is 1 only when DCO-off is 1 and neither the main clock nor the subsystem clock draws from the DCO. A clock draws from its source while its mode request is on or while its gate is still open.
- R7: `xt_pd` is 1 only when crystal-off is 1 and neither the main clock nor the subsystem clock draws from the crystal, using the same rule as R6.
- R8: A cycle with `irq_take` copies the mode bits into `saved_o` and clears all four mode bits.
- R9: A cycle with `irq_ret` loads the mode bits from `restore_mode` in one cycle and leaves `saved_o` unchanged.
- R10: When more than one update is requested in the same cycle, `irq_take` wins over `irq_ret`, and `irq_ret` wins over `sr_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_we | input | 1 | Status word write strobe |
| sr_wdata | input | SR_W | Status word value |
| selm | input | 2 | Main clock source select (bit 1 used) |
| sels | input | 1 | Subsystem clock source select |
| dco_ph | input | 1 | DCO clock phase |
| xt_ph | input | 1 | Crystal clock phase |
| irq_take | input | 1 | Interrupt accepted |
| irq_ret | input | 1 | Return from interrupt |
| restore_mode | input | 4 | Mode bits to reload on return |
| mode_o | output | 4 | Current mode bits |
| saved_o | output | 4 | Mode bits saved at interrupt entry |
| aclk_en | output | 1 | Auxiliary clock enable |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Subsystem clock enable |
| dco_pd | output | 1 | DCO power-down request |
| xt_pd | output | 1 | Crystal power-down request |

## Verification
The hardest state to reach is a gate that has gone stale: the mode bits already request a stop, but the selected source phase has stayed high on every edge since the request, so the gate is still open. The stimulus holds the DCO phase high across several edges after a write that turns off both clocks and the DCO. It then checks that both enables keep running and that the power-down request stays low. Next it drops the phase for one edge and checks that the gates close and `dco_pd` rises. The interrupt sequences load a restore value that differs from the saved one, and they raise competing update strobes in the same cycle.

// File: rtl/lp_clock_gate.sv
module lp_clock_gate #(
  parameter int SR_W     = 16,
  parameter int MODE_LSB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sr_we,
  input  logic [SR_W-1:0] sr_wdata,
  input  logic [1:0]      selm,
  input  logic            sels,
  input  logic            dco_ph,
  input  logic            xt_ph,
  input  logic            irq_take,
  input  logic            irq_ret,
  input  logic [3:0]      restore_mode,
  output logic [3:0]      mode_o,
  output logic [3:0]      saved_o,
  output logic            aclk_en,
  output logic            mclk_en,
  output logic            smclk_en,
  output logic            dco_pd,
  output logic            xt_pd
);
  localparam int MODE_W = 4;

  logic [MODE_W-1:0] mode_q, saved_q;
  logic gate_m, gate_s;
  logic m_ph, s_ph;
  logic dco_use, xt_use;

  wire sub_off  = mode_q[3];
  wire dco_off  = mode_q[2];
  wire xt_off   = mode_q[1];
  wire main_off = mode_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      saved_q <= '0;
    end else if (irq_take) begin
      saved_q <= mode_q;
      mode_q  <= '0;
    end else if (irq_ret) begin
      mode_q  <= restore_mode;
    end else if (sr_we) begin
      mode_q  <= sr_wdata[MODE_LSB +: MODE_W];
    end
  end

  assign m_ph = selm[1] ? xt_ph : dco_ph;
  assign s_ph = sels    ? xt_ph : dco_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_m <= 1'b0;
      gate_s <= 1'b0;
    end else begin
      if (!m_ph) gate_m <= ~main_off;
      if (!s_ph) gate_s <= ~sub_off;
    end
  end

  assign aclk_en  = xt_ph;
  assign mclk_en  = gate_m & m_ph;
  assign smclk_en = gate_s & s_ph;

  assign dco_use = ((gate_m | ~main_off) & ~selm[1]) | ((gate_s | ~sub_off) & ~sels);
  assign xt_use  = ((gate_m | ~main_off) &  selm[1]) | ((gate_s | ~sub_off) &  sels);
  assign dco_pd  = dco_off & ~dco_use;
  assign xt_pd   = xt_off & ~xt_use;

  assign mode_o  = mode_q;
  assign saved_o = saved_q;

  // R8
  irq_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (mode_q == '0) && (saved_q == $past(mode_q)));

  // R9
  irq_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_take) |=> (mode_q == $past(restore_mode)) && $stable(saved_q));

  // R5
  gate_m_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_m != $past(gate_m)) |-> !$past(m_ph));

  // R5
  gate_s_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_s != $past(gate_s)) |-> !$past(s_ph));

  // R6
  dco_pd_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dco_pd |-> !(mclk_en && !selm[1]) && !(smclk_en && !sels));

  // R7
  xt_pd_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xt_pd |-> !(mclk_en && selm[1]) && !(smclk_en && sels));
endmodule

// File: tb/test_lp_clock_gate.sv
module test_lp_clock_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_we = 1'b0;
  logic [15:0] sr_wdata = '0;
  logic [1:0] selm = '0;
  logic sels = 1'b0, dco_ph = 1'b0, xt_ph = 1'b0;
  logic irq_take = 1'b0, irq_ret = 1'b0;
  logic [3:0] restore_mode = '0;
  logic [3:0] mode_o, saved_o;
  logic aclk_en, mclk_en, smclk_en, dco_pd, xt_pd;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lp_clock_gate i_lp_clock_gate (
    .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_wdata(sr_wdata),
    .selm(selm), .sels(sels), .dco_ph(dco_ph), .xt_ph(xt_ph),
    .irq_take(irq_take), .irq_ret(irq_ret), .restore_mode(restore_mode),
    .mode_o(mode_o), .saved_o(saved_o), .aclk_en(aclk_en),
    .mclk_en(mclk_en), .smclk_en(smclk_en), .dco_pd(dco_pd), .xt_pd(xt_pd)
  );

  // {mode[3:0], selm1, sels, dco_ph, xt_ph, exp mclk, smclk, aclk, dco_pd, xt_pd}
  localparam logic [12:0] VEC [9] = '{
    13'b0000_0_0_1_1_1_1_1_0_0,
    13'b0001_0_0_1_0_0_1_0_0_0,
    13'b1001_0_0_1_1_0_0_1_0_0,
    13'b1101_0_0_1_1_0_0_1_1_0,
    13'b0100_1_0_1_1_1_1_1_0_0,
    13'b0110_1_1_1_0_0_0_0_1_0,
    13'b0111_1_1_1_1_0_1_1_1_0,
    13'b1011_1_1_1_1_0_0_1_0_1,
    13'b0010_0_0_0_1_0_0_1_0_1
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [15:0] w);
    sr_we = 1'b1; sr_wdata = w;
    step();
    sr_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 reset mode", {12'b0, mode_o}, 16'h0);
    chk("R1 reset saved", {12'b0, saved_o}, 16'h0);
    chk("R6 reset dco_pd", {15'b0, dco_pd}, 16'h0);
    chk("R7 reset xt_pd", {15'b0, xt_pd}, 16'h0);

    // R2 R3 R4 R6 R7 vector walk
    for (int i = 0; i < 9; i++) begin
      dco_ph = 1'b0; xt_ph = 1'b0;
      selm = {VEC[i][8], 1'b0}; sels = VEC[i][7];
      wr_mode({8'h00, VEC[i][12:9], 4'h0});
      step();
      dco_ph = VEC[i][6]; xt_ph = VEC[i][5];
      #1;
      chk($sformatf("R2 mclk vec%0d", i), {15'b0, mclk_en}, {15'b0, VEC[i][4]});
      chk($sformatf("R3 smclk vec%0d", i), {15'b0, smclk_en}, {15'b0, VEC[i][3]});
      chk($sformatf("R4 aclk vec%0d", i), {15'b0, aclk_en}, {15'b0, VEC[i][2]});
      chk($sformatf("R6 dco_pd vec%0d", i), {15'b0, dco_pd}, {15'b0, VEC[i][1]});
      chk($sformatf("R7 xt_pd vec%0d", i), {15'b0, xt_pd}, {15'b0, VEC[i][0]});
      @(negedge clk);
    end

    // R1 other bits ignored, bit 4 lands in mode_o[0]
    dco_ph = 1'b0; xt_ph = 1'b0;
    wr_mode(16'hFF0F);
    chk("R1 ignore others", {12'b0, mode_o}, 16'h0);
    wr_mode(16'h0010);
    chk("R1 main-off bit", {12'b0, mode_o}, 16'h1);
    selm = 2'b01;
    wr_mode(16'h0000);
    step();
    dco_ph = 1'b1; #1;
    chk("R2 selm0 no effect", {15'b0, mclk_en}, 16'h1);

    // R5 stale gate while phase held high
    selm = 2'b00; sels = 1'b0;
    wr_mode(16'h00D0);
    step(); step();
    chk("R5 main gate held", {15'b0, mclk_en}, 16'h1);
    chk("R5 sub gate held", {15'b0, smclk_en}, 16'h1);
    chk("R6 no pd while gate open", {15'b0, dco_pd}, 16'h0);
    dco_ph = 1'b0;
    step();
    chk("R6 pd after gates close", {15'b0, dco_pd}, 16'h1);
    dco_ph = 1'b1; #1;
    chk("R5 main gate closed", {15'b0, mclk_en}, 16'h0);
    chk("R5 sub gate closed", {15'b0, smclk_en}, 16'h0);

    // R8 R9 interrupt save and restore
    @(negedge clk);
    dco_ph = 1'b0;
    wr_mode(16'h00B0);
    step();
    chk("R1 mode loaded", {12'b0, mode_o}, 16'hB);
    irq_take = 1'b1; step(); irq_take = 1'b0;
    chk("R8 mode cleared", {12'b0, mode_o}, 16'h0);
    chk("R8 mode saved", {12'b0, saved_o}, 16'hB);
    step();
    dco_ph = 1'b1; #1;
    chk("R8 main runs in handler", {15'b0, mclk_en}, 16'h1);
    @(negedge clk);
    irq_ret = 1'b1; restore_mode = 4'h1; step(); irq_ret = 1'b0;
    chk("R9 restored mode", {12'b0, mode_o}, 16'h1);
    chk("R9 saved kept", {12'b0, saved_o}, 16'hB);

    // R10 priority
    irq_ret = 1'b1; restore_mode = 4'h4; sr_we = 1'b1; sr_wdata = 16'h0020;
    step();
    irq_ret = 1'b0; sr_we = 1'b0;
    chk("R10 ret over write", {12'b0, mode_o}, 16'h4);
    irq_take = 1'b1; irq_ret = 1'b1; restore_mode = 4'h8; sr_we = 1'b1; sr_wdata = 16'h00F0;
    step();
    irq_take = 1'b0; irq_ret = 1'b0; sr_we = 1'b0;
    chk("R10 take wins mode", {12'b0, mode_o}, 16'h0);
    chk("R10 take wins saved", {12'b0, saved_o}, 16'h4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule